// File: doc/BRIEF.md
# Two-Bit Symbol Unpacker with Length Rewrite

This streaming block takes packets of wide data words and splits every word into 2-bit symbols. Each symbol leaves in its own output word, right-justified in the two lowest bits, with all higher bits cleared. No amplitude or constellation mapping is applied, so an output word can take only four values. With the default widths, every 32-bit input word becomes sixteen output words.

Each packet arrives with a context bundle: a timestamp, a flag that says whether the timestamp is valid, a length, an end-of-vector flag and an end-of-burst flag. The payload grows by the expansion ratio, so the block multiplies the length field by that ratio. This lets downstream logic read the whole expanded payload. The other context fields pass through unchanged. The block handles one packet at a time. It accepts the context first, then presents the rewritten context at its output, and only after that handshake does it accept and unpack payload words until the word marked last has been fully emitted.

Payload channels use valid/ready/last handshakes. The context channels use valid/ready. Reset is synchronous and active high.

Top module: `bitpair_unpacker`

## Requirements
- R1: Each output word carries one input symbol in bits 1:0 and zero in bits 31:2.
- R2: The sixteen symbols of an input word leave in ascending order: bits 1:0 first, then 3:2, and so on up to 31:30.
- R3: Every accepted input word produces exactly sixteen output transfers. Backpressure causes no loss and no duplication.
- R4: The output length equals the input length times sixteen, on a port four bits wider than the input length, so it never overflows. Payload framing follows the last flag, not the length value.
- R5: Timestamp, timestamp-valid flag, end-of-vector and end-of-burst are forwarded unchanged.
- R6: The output last flag is high only on the sixteenth symbol of the input word that carried last.
- R7: Input payload ready is low from the cycle after a word is accepted until that word's final symbol has been transferred.
- R8: A packet's context is transferred at the output before any of its payload words is offered. Input payload is not accepted while output context is pending.
- R9: An output held valid without ready keeps its valid, data, last and context fields stable.
- R10: A synchronous reset clears both output valids and any partly unpacked word, so the next packet starts from its own first symbol. After reset, context ready is high and payload ready is low.
- R11: A new input context is accepted only after the previous packet's final symbol has been transferred. Context ready and payload ready are never high together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| s_ctx_valid | input | 1 | Input context valid |
| s_ctx_ready | output | 1 | Input context ready |
| s_ctx_time | input | 64 | Input timestamp |
| s_ctx_has_time | input | 1 | Input timestamp valid flag |
| s_ctx_len | input | 16 | Input payload length |
| s_ctx_eov | input | 1 | Input end-of-vector flag |
| s_ctx_eob | input | 1 | Input end-of-burst flag |
| s_dat_data | input | 32 | Input payload word |
| s_dat_last | input | 1 | Last input word of the packet |
| s_dat_valid | input | 1 | Input payload valid |
| s_dat_ready | output | 1 | Input payload ready |
| m_ctx_valid | output | 1 | Output context valid |
| m_ctx_ready | input | 1 | Output context ready |
| m_ctx_time | output | 64 | Forwarded timestamp |
| m_ctx_has_time | output | 1 | Forwarded timestamp valid flag |
| m_ctx_len | output | 20 | Scaled payload length |
| m_ctx_eov | output | 1 | Forwarded end-of-vector flag |
| m_ctx_eob | output | 1 | Forwarded end-of-burst flag |
| m_dat_data | output | 32 | Output symbol word |
| m_dat_last | output | 1 | Last output word of the packet |
| m_dat_valid | output | 1 | Output payload valid |
| m_dat_ready | input | 1 | Output payload ready |

## Verification
Several properties are checked on every cycle:
- context ready and payload ready are never high together;
- payload is never offered while context is pending;
- input ready drops after each accepted word;
- stalled outputs stay stable;
- the scaled length and forwarded fields appear one cycle after capture.

Other behaviours only the bench's packet sweeps can show. These are the symbol values and their ascending order, the exact count per word, where last falls in multi-word packets under four backpressure patterns, and the discard of a partly emitted word by a reset mid-packet.

// File: rtl/pu_pkg.sv
package pu_pkg;

   typedef enum logic [1:0] {
      PH_CTX_IN  = 2'd0,
      PH_CTX_OUT = 2'd1,
      PH_DATA    = 2'd2
   } pu_phase_e;

   function automatic bit is_pow2(input int v);
      return (v > 0) && ((v & (v - 1)) == 0);
   endfunction

endpackage

// File: rtl/pu_phase_fsm.sv
module pu_phase_fsm
   import pu_pkg::*;
(
   input  logic      clk,
   input  logic      rst,
   input  logic      ctx_in_fire,
   input  logic      ctx_out_fire,
   input  logic      pkt_done,
   output pu_phase_e phase
);

   pu_phase_e phase_q;
   pu_phase_e phase_d;

   always_comb begin
      phase_d = phase_q;
      unique case (phase_q)
         PH_CTX_IN:  if (ctx_in_fire)  phase_d = PH_CTX_OUT;
         PH_CTX_OUT: if (ctx_out_fire) phase_d = PH_DATA;
         PH_DATA:    if (pkt_done)     phase_d = PH_CTX_IN;
         default:                      phase_d = PH_CTX_IN;
      endcase
   end

   always_ff @(posedge clk) begin
      if (rst) phase_q <= PH_CTX_IN;
      else     phase_q <= phase_d;
   end

   assign phase = phase_q;

   // R10: first cycle after reset is always the context-intake phase
   a_r10_reset_phase: assert property (@(posedge clk)
      $past(rst) |-> phase_q == PH_CTX_IN);

   // R11: a packet ends only while payload is being processed
   a_r11_done_in_data: assert property (@(posedge clk) disable iff (rst)
      pkt_done |-> phase_q == PH_DATA);

endmodule

// File: rtl/pu_ctx_stage.sv
module pu_ctx_stage #(
   parameter int LEN_W  = 16,
   parameter int TIME_W = 64,
   parameter int RATIO  = 16,
   parameter int OLEN_W = 20
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              load,
   input  logic              hold,
   input  logic [TIME_W-1:0] i_time,
   input  logic              i_has_time,
   input  logic [LEN_W-1:0]  i_len,
   input  logic              i_eov,
   input  logic              i_eob,
   output logic [TIME_W-1:0] o_time,
   output logic              o_has_time,
   output logic [OLEN_W-1:0] o_len,
   output logic              o_eov,
   output logic              o_eob
);

   logic [OLEN_W-1:0] len_scaled;
   logic [OLEN_W-1:0] len_wide;

   assign len_wide = OLEN_W'(i_len);

   generate
      if (pu_pkg::is_pow2(RATIO)) begin : g_shift
         localparam int SH = $clog2(RATIO);
         assign len_scaled = len_wide << SH;
      end else begin : g_mult
         assign len_scaled = len_wide * OLEN_W'(RATIO);
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (rst) begin
         o_time     <= '0;
         o_has_time <= 1'b0;
         o_len      <= '0;
         o_eov      <= 1'b0;
         o_eob      <= 1'b0;
      end else if (load) begin
         o_time     <= i_time;
         o_has_time <= i_has_time;
         o_len      <= len_scaled;
         o_eov      <= i_eov;
         o_eob      <= i_eob;
      end
   end

   a_r4_len_scaled: assert property (@(posedge clk) disable iff (rst)
      load |=> o_len == OLEN_W'($past(i_len)) * OLEN_W'(RATIO));

   a_r5_fields_forwarded: assert property (@(posedge clk) disable iff (rst)
      load |=> (o_time == $past(i_time)) && (o_has_time == $past(i_has_time))
               && (o_eov == $past(i_eov)) && (o_eob == $past(i_eob)));

   a_r9_ctx_stable: assert property (@(posedge clk) disable iff (rst)
      hold && !load |=> $stable(o_len) && $stable(o_time) && $stable(o_eob));

endmodule

// File: rtl/pu_slicer.sv
module pu_slicer #(
   parameter int IN_W  = 32,
   parameter int SYM_W = 2,
   parameter int OUT_W = 32,
   parameter int RATIO = 16,
   parameter int CNT_W = 4
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             en,
   input  logic [IN_W-1:0]  s_data,
   input  logic             s_last,
   input  logic             s_valid,
   output logic             s_ready,
   output logic [OUT_W-1:0] m_data,
   output logic             m_last,
   output logic             m_valid,
   input  logic             m_ready,
   output logic             pkt_done
);

   localparam logic [CNT_W-1:0] LAST_IDX = CNT_W'(RATIO - 1);

   logic [IN_W-1:0]  hold_q;
   logic             last_q;
   logic             busy_q;
   logic [CNT_W-1:0] cnt_q;
   logic             at_end;
   logic [SYM_W-1:0] pieces [RATIO];

   genvar g;
   generate
      for (g = 0; g < RATIO; g++) begin : g_piece
         assign pieces[g] = hold_q[g*SYM_W +: SYM_W];
      end
      if (OUT_W > SYM_W) begin : g_pad
         assign m_data = {{(OUT_W-SYM_W){1'b0}}, pieces[cnt_q]};
      end else begin : g_nopad
         assign m_data = pieces[cnt_q];
      end
   endgenerate

   assign at_end   = (cnt_q == LAST_IDX);
   assign s_ready  = en && !busy_q;
   assign m_valid  = busy_q;
   assign m_last   = busy_q && last_q && at_end;
   assign pkt_done = busy_q && m_ready && at_end && last_q;

   always_ff @(posedge clk) begin
      if (rst) begin
         hold_q <= '0;
         last_q <= 1'b0;
         busy_q <= 1'b0;
         cnt_q  <= '0;
      end else if (s_valid && s_ready) begin
         hold_q <= s_data;
         last_q <= s_last;
         busy_q <= 1'b1;
         cnt_q  <= '0;
      end else if (busy_q && m_ready) begin
         if (at_end) begin
            busy_q <= 1'b0;
            cnt_q  <= '0;
         end else begin
            cnt_q <= cnt_q + 1'b1;
         end
      end
   end

   a_r7_ready_drops: assert property (@(posedge clk) disable iff (rst)
      s_valid && s_ready |=> !s_ready && m_valid);

   a_r3_no_early_release: assert property (@(posedge clk) disable iff (rst)
      m_valid && m_ready && !at_end |=> m_valid && !s_ready);

   a_r2_ascending: assert property (@(posedge clk) disable iff (rst)
      m_valid && m_ready && !at_end |=> cnt_q == $past(cnt_q) + 1'b1);

   a_r9_data_stable: assert property (@(posedge clk) disable iff (rst)
      m_valid && !m_ready |=> m_valid && $stable(m_data) && $stable(m_last));

endmodule

// File: rtl/bitpair_unpacker.sv
module bitpair_unpacker
   import pu_pkg::*;
#(
   parameter int IN_W   = 32,
   parameter int SYM_W  = 2,
   parameter int OUT_W  = 32,
   parameter int LEN_W  = 16,
   parameter int TIME_W = 64,
   localparam int RATIO  = IN_W / SYM_W,
   localparam int CNT_W  = (RATIO > 1) ? $clog2(RATIO) : 1,
   localparam int OLEN_W = LEN_W + $clog2(RATIO)
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              s_ctx_valid,
   output logic              s_ctx_ready,
   input  logic [TIME_W-1:0] s_ctx_time,
   input  logic              s_ctx_has_time,
   input  logic [LEN_W-1:0]  s_ctx_len,
   input  logic              s_ctx_eov,
   input  logic              s_ctx_eob,
   input  logic [IN_W-1:0]   s_dat_data,
   input  logic              s_dat_last,
   input  logic              s_dat_valid,
   output logic              s_dat_ready,
   output logic              m_ctx_valid,
   input  logic              m_ctx_ready,
   output logic [TIME_W-1:0] m_ctx_time,
   output logic              m_ctx_has_time,
   output logic [OLEN_W-1:0] m_ctx_len,
   output logic              m_ctx_eov,
   output logic              m_ctx_eob,
   output logic [OUT_W-1:0]  m_dat_data,
   output logic              m_dat_last,
   output logic              m_dat_valid,
   input  logic              m_dat_ready
);

   generate
      if (IN_W % SYM_W != 0) begin : g_bad_ratio
         $error("input width must be a multiple of the symbol width");
      end
      if (OUT_W < SYM_W) begin : g_bad_out
         $error("output width must hold one symbol");
      end
      if (RATIO < 2) begin : g_bad_expand
         $error("expansion ratio must be at least two");
      end
   endgenerate

   pu_phase_e phase;
   logic      ctx_in_fire;
   logic      ctx_out_fire;
   logic      pkt_done;

   assign s_ctx_ready  = (phase == PH_CTX_IN);
   assign m_ctx_valid  = (phase == PH_CTX_OUT);
   assign ctx_in_fire  = s_ctx_valid && s_ctx_ready;
   assign ctx_out_fire = m_ctx_valid && m_ctx_ready;

   pu_phase_fsm i_fsm (
      .clk          (clk),
      .rst          (rst),
      .ctx_in_fire  (ctx_in_fire),
      .ctx_out_fire (ctx_out_fire),
      .pkt_done     (pkt_done),
      .phase        (phase)
   );

   pu_ctx_stage #(
      .LEN_W  (LEN_W),
      .TIME_W (TIME_W),
      .RATIO  (RATIO),
      .OLEN_W (OLEN_W)
   ) i_ctx (
      .clk        (clk),
      .rst        (rst),
      .load       (ctx_in_fire),
      .hold       (m_ctx_valid && !m_ctx_ready),
      .i_time     (s_ctx_time),
      .i_has_time (s_ctx_has_time),
      .i_len      (s_ctx_len),
      .i_eov      (s_ctx_eov),
      .i_eob      (s_ctx_eob),
      .o_time     (m_ctx_time),
      .o_has_time (m_ctx_has_time),
      .o_len      (m_ctx_len),
      .o_eov      (m_ctx_eov),
      .o_eob      (m_ctx_eob)
   );

   pu_slicer #(
      .IN_W  (IN_W),
      .SYM_W (SYM_W),
      .OUT_W (OUT_W),
      .RATIO (RATIO),
      .CNT_W (CNT_W)
   ) i_slicer (
      .clk      (clk),
      .rst      (rst),
      .en       (phase == PH_DATA),
      .s_data   (s_dat_data),
      .s_last   (s_dat_last),
      .s_valid  (s_dat_valid),
      .s_ready  (s_dat_ready),
      .m_data   (m_dat_data),
      .m_last   (m_dat_last),
      .m_valid  (m_dat_valid),
      .m_ready  (m_dat_ready),
      .pkt_done (pkt_done)
   );

   a_r8_ctx_before_data: assert property (@(posedge clk) disable iff (rst)
      m_ctx_valid |-> !m_dat_valid && !s_dat_ready);

   a_r11_one_side_ready: assert property (@(posedge clk) disable iff (rst)
      !(s_ctx_ready && s_dat_ready));

   a_r9_ctx_valid_held: assert property (@(posedge clk) disable iff (rst)
      m_ctx_valid && !m_ctx_ready |=> m_ctx_valid);

   a_r6_last_ends_packet: assert property (@(posedge clk) disable iff (rst)
      m_dat_valid && m_dat_ready && m_dat_last |=> !m_dat_valid && s_ctx_ready);

endmodule

// File: tb/test_bitpair_unpacker.sv
module test_bitpair_unpacker;

   logic        clk = 1'b0;
   logic        rst = 1'b1;
   logic        s_ctx_valid = 1'b0;
   logic        s_ctx_ready;
   logic [63:0] s_ctx_time = '0;
   logic        s_ctx_has_time = 1'b0;
   logic [15:0] s_ctx_len = '0;
   logic        s_ctx_eov = 1'b0;
   logic        s_ctx_eob = 1'b0;
   logic [31:0] s_dat_data = '0;
   logic        s_dat_last = 1'b0;
   logic        s_dat_valid = 1'b0;
   logic        s_dat_ready;
   logic        m_ctx_valid;
   logic        m_ctx_ready = 1'b0;
   logic [63:0] m_ctx_time;
   logic        m_ctx_has_time;
   logic [19:0] m_ctx_len;
   logic        m_ctx_eov;
   logic        m_ctx_eob;
   logic [31:0] m_dat_data;
   logic        m_dat_last;
   logic        m_dat_valid;
   logic        m_dat_ready = 1'b0;

   always #10 clk = ~clk;

   bitpair_unpacker i_bitpair_unpacker (.*);

   int n_chk = 0;
   int n_fail = 0;
   int mode = 0;
   int budget = 1000000;
   int cyc = 0;
   bit timeout = 0;

   logic [32:0] exp_d [$];
   logic [19:0] exp_len [$];
   logic [63:0] exp_time [$];
   logic [2:0]  exp_fl [$];

   logic        st_pend = 1'b0;
   logic [31:0] st_data;
   logic        st_last;

   task automatic chk(input bit ok, input string req, input string what,
                      input logic [63:0] act, input logic [63:0] exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
      end
   endtask

   function automatic bit pat(input int m, input int c);
      case (m)
         0:       return 1'b1;
         1:       return (c % 2) == 0;
         2:       return (c % 3) == 0;
         default: return (((c * 7) ^ (c >> 2)) & 1) == 1;
      endcase
   endfunction

   // consumer and per-cycle observers
   always @(negedge clk) begin
      bit rdy;
      bit crdy;
      logic [32:0] e;
      cyc++;
      if (rst) begin
         m_dat_ready = 1'b0;
         m_ctx_ready = 1'b0;
         st_pend = 1'b0;
      end else begin
         rdy  = pat(mode, cyc) && (budget > 0);
         crdy = pat(mode, cyc + 1);
         m_dat_ready = rdy;
         m_ctx_ready = crdy;
         if (st_pend) begin
            chk(m_dat_valid && m_dat_data == st_data && m_dat_last == st_last,
                "R9", "stalled word held", {31'd0, m_dat_last, m_dat_data}, {31'd0, st_last, st_data});
         end
         st_pend = m_dat_valid && !rdy;
         st_data = m_dat_data;
         st_last = m_dat_last;
         if (m_dat_valid) begin
            chk(!s_dat_ready, "R7", "input ready while unpacking", 64'(s_dat_ready), 0);
            chk(!m_ctx_valid, "R8", "context pending with payload", 64'(m_ctx_valid), 0);
            chk(!s_ctx_ready, "R11", "context ready mid packet", 64'(s_ctx_ready), 0);
         end
         if (m_ctx_valid)
            chk(!s_dat_ready, "R8", "payload ready with context pending", 64'(s_dat_ready), 0);
         if (m_dat_valid && rdy) begin
            budget--;
            if (exp_d.size() == 0) begin
               chk(0, "R3", "extra output word", 64'(m_dat_data), 0);
            end else begin
               e = exp_d.pop_front();
               chk(m_dat_data == e[31:0], "R1 R2", "symbol word", 64'(m_dat_data), 64'(e[31:0]));
               chk(m_dat_last == e[32], "R6", "last flag", 64'(m_dat_last), 64'(e[32]));
            end
         end
         if (m_ctx_valid && crdy) begin
            if (exp_len.size() == 0) begin
               chk(0, "R8", "unexpected context", 64'(m_ctx_len), 0);
            end else begin
               logic [19:0] el;
               logic [63:0] et;
               logic [2:0]  ef;
               el = exp_len.pop_front();
               et = exp_time.pop_front();
               ef = exp_fl.pop_front();
               chk(m_ctx_len == el, "R4", "scaled length", 64'(m_ctx_len), 64'(el));
               chk(m_ctx_time == et, "R5", "timestamp", m_ctx_time, et);
               chk({m_ctx_has_time, m_ctx_eov, m_ctx_eob} == ef, "R5", "flags",
                   64'({m_ctx_has_time, m_ctx_eov, m_ctx_eob}), 64'(ef));
            end
         end
      end
   end

   function automatic logic [31:0] word_of(input int p, input int i);
      if (p == 0) begin
         case (i)
            0:       return 32'hE4E4_E4E4;
            1:       return 32'h0000_0000;
            2:       return 32'hFFFF_FFFF;
            default: return 32'h1B1B_1B1B;
         endcase
      end
      return (32'(p) * 32'h9E37_79B9) ^ (32'(i) * 32'h7F4A_7C15) ^ 32'h5A5A_0F0F;
   endfunction

   task automatic send_ctx(input logic [15:0] lenf, input int p);
      logic [63:0] t;
      logic [2:0]  f;
      t = {32'(p) * 32'h0100_0193, 32'hA5A5_0000 | 32'(p)};
      f = 3'(p);
      exp_len.push_back(20'(lenf) * 20'd16);
      exp_time.push_back(t);
      exp_fl.push_back(f);
      s_ctx_time = t;
      {s_ctx_has_time, s_ctx_eov, s_ctx_eob} = f;
      s_ctx_len = lenf;
      s_ctx_valid = 1'b1;
      while (!s_ctx_ready) @(negedge clk);
      @(negedge clk);
      s_ctx_valid = 1'b0;
   endtask

   task automatic put_word(input logic [31:0] w, input bit last);
      for (int k = 0; k < 16; k++)
         exp_d.push_back({last && (k == 15), 30'd0, w[2*k +: 2]});
      s_dat_data = w;
      s_dat_last = last;
      s_dat_valid = 1'b1;
      while (!s_dat_ready) @(negedge clk);
      @(negedge clk);
      s_dat_valid = 1'b0;
   endtask

   task automatic send_pkt(input logic [15:0] lenf, input int nw, input int p);
      send_ctx(lenf, p);
      for (int i = 0; i < nw; i++) put_word(word_of(p, i), i == nw - 1);
   endtask

   task automatic drain();
      int guard;
      guard = 0;
      while ((exp_d.size() != 0 || exp_len.size() != 0) && guard < 2000) begin
         @(negedge clk);
         guard++;
      end
   endtask

   task automatic run_all();
      repeat (3) @(negedge clk);
      // R10: state after reset
      chk(!m_dat_valid && !m_ctx_valid, "R10", "outputs idle after reset",
          64'({m_dat_valid, m_ctx_valid}), 0);
      chk(s_ctx_ready && !s_dat_ready, "R10", "ready levels after reset",
          64'({s_ctx_ready, s_dat_ready}), 64'(2'b10));
      rst = 1'b0;
      @(negedge clk);
      // sweep packet lengths under four backpressure patterns
      for (int m = 0; m < 4; m++) begin
         mode = m;
         for (int n = 1; n <= 4; n++) send_pkt(16'(n), n, m * 8 + n - 1 - ((m == 0 && n == 4) ? 3 : 0));
         drain();
      end
      // R4: largest length field, framing set by last alone
      mode = 0;
      send_pkt(16'hFFFF, 1, 9);
      send_pkt(16'h0000, 2, 10);
      drain();
      // R10: reset while a word is partly emitted
      mode = 1;
      budget = 5;
      send_ctx(16'd2, 11);
      put_word(32'hDEAD_BEEF, 1'b0);
      repeat (20) @(negedge clk);
      chk(m_dat_valid && !s_dat_ready, "R10", "word stalled mid-unpack",
          64'({m_dat_valid, s_dat_ready}), 64'(2'b10));
      rst = 1'b1;
      exp_d.delete();
      exp_len.delete();
      exp_time.delete();
      exp_fl.delete();
      repeat (2) @(negedge clk);
      rst = 1'b0;
      budget = 1000000;
      chk(!m_dat_valid && !m_ctx_valid, "R10", "partial word discarded",
          64'({m_dat_valid, m_ctx_valid}), 0);
      chk(s_ctx_ready && !s_dat_ready, "R10", "ready levels after mid reset",
          64'({s_ctx_ready, s_dat_ready}), 64'(2'b10));
      send_pkt(16'd1, 1, 12);
      drain();
      chk(exp_d.size() == 0, "R3", "words outstanding at end", 64'(exp_d.size()), 0);
      chk(exp_len.size() == 0, "R8", "contexts outstanding at end", 64'(exp_len.size()), 0);
   endtask

   initial begin
      fork
         run_all();
         begin
            repeat (100000) @(posedge clk);
            timeout = 1;
         end
      join_any
      disable fork;
      if (timeout) chk(0, "R3", "watchdog expired", 0, 1);
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end

endmodule